// File: doc/BRIEF.md
# Synchronous Burst SRAM with Control Front-End

This block is a synthesizable model of a small synchronous burst SRAM together with the control logic in front of it. On each rising clock edge it samples the chip enables and two address strobes. From these it loads a new start address, deselects itself, or keeps the current burst. A burst advance input steps a 2-bit counter. The counter is applied to the two low address bits in interleaved order or in linear order, as chosen by a static order-select pin. Each selected cycle is decoded as a read or as a write with a byte mask, using a global write, a byte-write enable and one strobe per byte lane.

Read data is shown combinationally for the current burst address. It is driven only when the asynchronous output enable is active. The bus is modelled as a data output plus a drive flag; when the flag is low the output is zero, which stands for high-impedance. A snooze input freezes the block and keeps the array contents. After snooze is released, a recovery window of a set number of clock cycles follows. During that window writes are refused, while loads, reads and deselects are still accepted.

Top module: `sburst_sram`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block becomes deselected, the recovery window closes and every array word is cleared. After that edge, `dq_oe` and `recov_busy` read 0.
- R2: A low `strobe_p_n` with `ce_main_n` low loads `addr` as burst start if `ce_hi` is high and `ce_lo_n` is low, and deselects otherwise. When `ce_main_n` is high, `strobe_p_n` is ignored.
- R3: A low `strobe_c_n`, when R2 does not apply, loads `addr` if `ce_main_n` is low, `ce_hi` is high and `ce_lo_n` is low, and deselects otherwise.
- R4: With no load or deselect, a low `adv_n` while selected adds 1 (mod 4) to the beat counter. When `order_sel` is 1, the two low address bits are the start bits XOR the counter, and the upper bits stay fixed.
- R5: When `order_sel` is 0, the two low address bits are (start bits + counter) mod 4, and the upper bits stay fixed.
- R6: A low `gw_n` in a selected cycle writes all four lanes of `din` to the cycle's address, whatever `bwe_n` and `bw_n` are.
- R7: With `gw_n` high and `bwe_n` low, lane i (bits [i*LANE_W +: LANE_W]) is written only if `bw_n[i]` is 0. If no `bw_n` bit is 0, the cycle is a read.
- R8: With `gw_n` and `bwe_n` both high, the cycle is a read whatever `bw_n` is.
- R9: `dq_oe` is high exactly when the block is selected, the last selected cycle was a read, `oe_n` is low and `snooze` is low. `dq_out` then carries the word at the current burst address, and it is 0 whenever `dq_oe` is low.
- R10: At an edge where `snooze` is high, all other inputs are ignored, the block deselects and no word is written. While `snooze` is high, `dq_oe` is low at once.
- R11: Counting from the release of `snooze`, the first RECOVER_CYC clock edges refuse writes, and `recov_busy` is high until those edges have passed. Loads and reads are still accepted during this window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Burst start address |
| ce_main_n | input | 1 | Master chip enable, active low |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Secondary chip enable, active low |
| strobe_p_n | input | 1 | Processor-side address strobe, active low |
| strobe_c_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write strobes, active low |
| order_sel | input | 1 | 1 = interleaved burst, 0 = linear burst |
| oe_n | input | 1 | Asynchronous output enable, active low |
| snooze | input | 1 | Low-power hold, active high |
| din | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Read data, 0 when not driven |
| dq_oe | output | 1 | Data bus drive flag |
| recov_busy | output | 1 | Recovery window after snooze is open |

## Verification
The hardest case to reach is the recovery window. It needs snooze held across several edges that also carry write commands, then released, and then a write in each of the first edges after release. Those writes must be refused, and a write on the edge just after the window must land. The stimulus does this in sequence and then reads back every affected word. The bench's behavioural model tracks the window with its own countdown, so an off-by-one in the window length shows up as a data mismatch. The two burst orders are run from every start offset within a group of four, and the output enable is toggled in the middle of a burst.

// File: rtl/sburst_pkg.sv
// Package: shared command type and burst-order arithmetic for the burst SRAM.
// Assumes the burst covers the two low address bits only.
package sburst_pkg;

    typedef enum logic [1:0] {
        CMD_KEEP  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_DESEL = 2'd2
    } sb_cmd_e;

    // Low two address bits for a given beat of a burst.
    function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       interleave);
        return interleave ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/sb_burst_seq.sv
// Module: address strobe qualification and burst address sequencer.
// Holds the select flag, the start address and the beat counter. Gives the
// address for the current state and for the state after the coming edge.
// Assumes order_sel is static while a burst runs.
module sb_burst_seq
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_main_n,
    input  logic              ce_hi,
    input  logic              ce_lo_n,
    input  logic              strobe_p_n,
    input  logic              strobe_c_n,
    input  logic              adv_n,
    input  logic              order_sel,
    output logic              sel_q,
    output logic              sel_nx,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr
);
    logic [ADDR_W-1:0] base_q, base_nx;
    logic [1:0]        beat_q, beat_nx;
    logic              all_en;
    sb_cmd_e           cmd;

    // Decode the strobes: the processor strobe only counts with master enable low.
    always_comb begin
        all_en = !ce_main_n && ce_hi && !ce_lo_n;
        if ((!strobe_p_n && !ce_main_n) || !strobe_c_n)
            cmd = all_en ? CMD_LOAD : CMD_DESEL;
        else
            cmd = CMD_KEEP;
    end

    // Next-state selection for select flag, start address and beat counter.
    always_comb begin
        sel_nx  = sel_q;
        base_nx = base_q;
        beat_nx = beat_q;
        if (hold) begin
            sel_nx = 1'b0;
        end else if (cmd == CMD_LOAD) begin
            sel_nx  = 1'b1;
            base_nx = addr;
            beat_nx = 2'd0;
        end else if (cmd == CMD_DESEL) begin
            sel_nx = 1'b0;
        end else if (!adv_n && sel_q) begin
            beat_nx = beat_q + 2'd1;
        end
    end

    // Form the burst address for the present and the next state.
    always_comb begin
        cur_addr = {base_q[ADDR_W-1:2],  burst_lsb(base_q[1:0],  beat_q,  order_sel)};
        nxt_addr = {base_nx[ADDR_W-1:2], burst_lsb(base_nx[1:0], beat_nx, order_sel)};
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            base_q <= '0;
            beat_q <= 2'd0;
        end else begin
            sel_q  <= sel_nx;
            base_q <= base_nx;
            beat_q <= beat_nx;
        end
    end

    p_ce0_blocks_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_main_n && strobe_c_n && adv_n && !hold)
        |=> ($stable(base_q) && $stable(beat_q) && $stable(sel_q)));

    p_adv_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && strobe_c_n && (strobe_p_n || ce_main_n) && !adv_n && sel_q)
        |=> (beat_q == $past(beat_q) + 2'd1));

endmodule

// File: rtl/sb_wr_decode.sv
// Module: write-enable hierarchy decoder.
// Global write covers every lane. Otherwise the byte-write enable passes the
// per-lane strobes. Assumes 'active' already includes selection and no snooze.
module sb_wr_decode #(
    parameter int LANES = 4
) (
    input  logic             active,
    input  logic             block,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_we,
    output logic             is_read
);
    // Per-lane enable: global write wins, else byte enable with lane strobe.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_we[i] = active && !block && (!gw_n || (!bwe_n && !bw_n[i]));
    end

    // A cycle with no enabled lane is a read.
    assign is_read = (lane_we == '0);

endmodule

// File: rtl/sb_snooze_ctl.sv
// Module: recovery window after snooze release.
// Reloads a countdown on every edge with snooze high and counts it down after
// release. A non-zero count refuses writes at that edge.
module sb_snooze_ctl #(
    parameter int RECOVER_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic snooze,
    output logic busy
);
    localparam int CW = $clog2(RECOVER_CYC + 2);
    localparam logic [CW-1:0] RELOAD = CW'(RECOVER_CYC);

    logic [CW-1:0] left_q;

    // Countdown register for the recovery window.
    always_ff @(posedge clk) begin
        if (!rst_n)          left_q <= '0;
        else if (snooze)     left_q <= RELOAD;
        else if (left_q != 0) left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);

    if (RECOVER_CYC > 0) begin : g_chk
        p_window_opens_r11: assert property (@(posedge clk) disable iff (!rst_n)
            snooze |=> busy);
    end

endmodule

// File: rtl/sburst_sram.sv
// Module: synchronous burst SRAM with control front-end (top).
// Storage is a small register array, one word per address, split into lanes.
// Read data is flow-through from the current burst address. The drive flag
// models the high-impedance state. Assumes order_sel is static.
module sburst_sram
    import sburst_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int LANES       = 4,
    parameter int LANE_W      = 9,
    parameter int RECOVER_CYC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ce_main_n,
    input  logic                    ce_hi,
    input  logic                    ce_lo_n,
    input  logic                    strobe_p_n,
    input  logic                    strobe_c_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    order_sel,
    input  logic                    oe_n,
    input  logic                    snooze,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe,
    output logic                    recov_busy
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = LANES * LANE_W;

    logic              sel_q, sel_nx, rd_q, is_read;
    logic [ADDR_W-1:0] cur_addr, nxt_addr;
    logic [LANES-1:0]  lane_we;
    logic [WORD_W-1:0] rd_word;
    logic [LANE_W-1:0] mem [DEPTH][LANES];

    sb_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .hold(snooze), .addr(addr),
        .ce_main_n(ce_main_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
        .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n), .adv_n(adv_n),
        .order_sel(order_sel), .sel_q(sel_q), .sel_nx(sel_nx),
        .cur_addr(cur_addr), .nxt_addr(nxt_addr)
    );

    sb_snooze_ctl #(.RECOVER_CYC(RECOVER_CYC)) u_snz (
        .clk(clk), .rst_n(rst_n), .snooze(snooze), .busy(recov_busy)
    );

    sb_wr_decode #(.LANES(LANES)) u_wr (
        .active(sel_nx && !snooze), .block(recov_busy), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .lane_we(lane_we), .is_read(is_read)
    );

    // Remember whether the last selected cycle was a read.
    always_ff @(posedge clk) begin
        if (!rst_n)                rd_q <= 1'b0;
        else if (sel_nx && !snooze) rd_q <= is_read;
    end

    // One storage column per lane, each written by its own lane enable.
    for (genvar l = 0; l < LANES; l++) begin : g_col
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < DEPTH; w++) mem[w][l] <= '0;
            end else if (lane_we[l]) begin
                mem[nxt_addr][l] <= din[l*LANE_W +: LANE_W];
            end
        end
        assign rd_word[l*LANE_W +: LANE_W] = mem[cur_addr][l];
    end

    // Output gating: selected, read cycle, enable active, not snoozing.
    always_comb begin
        dq_oe  = sel_q && rd_q && !oe_n && !snooze;
        dq_out = dq_oe ? rd_word : '0;
    end

    p_snooze_deselects_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snooze |=> !sel_q);

    p_no_write_in_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
        recov_busy |-> (lane_we == '0));

    p_drive_needs_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(sel_nx));

endmodule

// File: tb/sburst_sram_tb.sv
module sburst_sram_tb;
    localparam int AW = 6, LN = 4, LW = 9, REC = 2, DW = LN * LW, DEP = 1 << AW;

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] addr = '0;
    logic ce_main_n = 0, ce_hi = 1, ce_lo_n = 0;
    logic strobe_p_n = 1, strobe_c_n = 1, adv_n = 1;
    logic gw_n = 1, bwe_n = 1, order_sel = 1, oe_n = 0, snooze = 0;
    logic [LN-1:0] bw_n = '1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dq_out;
    logic dq_oe, recov_busy;

    int n_cmp = 0, n_bad = 0;
    string tag = "R1";
    bit done = 0;

    // reference model state
    bit m_sel, m_rd;
    int m_base, m_cnt, m_rec;
    logic [DW-1:0] m_mem [DEP];

    always #4 clk = ~clk;

    sburst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .RECOVER_CYC(REC)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_main_n(ce_main_n), .ce_hi(ce_hi),
        .ce_lo_n(ce_lo_n), .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
        .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .order_sel(order_sel),
        .oe_n(oe_n), .snooze(snooze), .din(din), .dq_out(dq_out), .dq_oe(dq_oe),
        .recov_busy(recov_busy));

    function automatic int ref_addr(int b, int c, bit il);
        int lo = b % 4;
        int up = b - lo;
        return il ? (up + (lo ^ c)) : (up + ((lo + c) % 4));
    endfunction

    function automatic logic [DW-1:0] pat(int k);
        return {9'(k * 11 + 1), 9'(k * 13 + 200), 9'(k * 17 + 77), 9'(k * 19 + 5)};
    endfunction

    task automatic model_edge();
        bit blocked, all_en, hit, ld, ds;
        int ea;
        if (!rst_n) begin
            m_sel = 0; m_rd = 0; m_base = 0; m_cnt = 0; m_rec = 0;
            for (int w = 0; w < DEP; w++) m_mem[w] = '0;
            return;
        end
        if (snooze) begin
            m_sel = 0; m_rec = REC;
            return;
        end
        blocked = (m_rec != 0);
        if (m_rec > 0) m_rec--;
        all_en = !ce_main_n && ce_hi && !ce_lo_n;
        hit = (!strobe_p_n && !ce_main_n) || !strobe_c_n;
        ld = hit && all_en;
        ds = hit && !all_en;
        if (ld) begin m_sel = 1; m_base = int'(addr); m_cnt = 0; end
        else if (ds) m_sel = 0;
        else if (!adv_n && m_sel) m_cnt = (m_cnt + 1) % 4;
        if (m_sel) begin
            bit any = 0;
            ea = ref_addr(m_base, m_cnt, order_sel);
            for (int l = 0; l < LN; l++) begin
                if (!blocked && (!gw_n || (!bwe_n && !bw_n[l]))) begin
                    m_mem[ea][l*LW +: LW] = din[l*LW +: LW];
                    any = 1;
                end
            end
            m_rd = !any;
        end
    endtask

    task automatic compare();
        bit e_oe = m_sel && m_rd && !oe_n && !snooze;
        logic [DW-1:0] e_dq = e_oe ? m_mem[ref_addr(m_base, m_cnt, order_sel)] : '0;
        bit e_busy = (m_rec != 0);
        n_cmp++;
        if (dq_oe !== e_oe || dq_out !== e_dq || recov_busy !== e_busy) begin
            n_bad++;
            $display("FAIL %s: oe=%0b dq=%h busy=%0b expected oe=%0b dq=%h busy=%0b",
                     tag, dq_oe, dq_out, recov_busy, e_oe, e_dq, e_busy);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic quiet();
        strobe_p_n = 1; strobe_c_n = 1; adv_n = 1;
        gw_n = 1; bwe_n = 1; bw_n = '1;
        ce_main_n = 0; ce_hi = 1; ce_lo_n = 0;
    endtask

    task automatic load_c(int a);
        quiet(); strobe_c_n = 0; addr = AW'(a);
    endtask

    task automatic read_burst(int a, int beats);
        load_c(a); tick();
        quiet();
        for (int b = 1; b < beats; b++) begin adv_n = 0; tick(); end
        quiet();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        tag = "R1"; rst_n = 0; quiet();
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1; tick();

        // R6: fill array with global-write bursts; byte inputs set to inactive noise
        tag = "R6";
        for (int g = 0; g < DEP / 4; g++) begin
            load_c(g * 4); gw_n = 0; bwe_n = 1; bw_n = 4'b0101; din = pat(g * 4); tick();
            for (int b = 1; b < 4; b++) begin
                quiet(); adv_n = 0; gw_n = 0; din = pat(g * 4 + b); tick();
            end
        end
        quiet();

        // R4: interleaved order from each start offset
        tag = "R4"; order_sel = 1;
        for (int s = 0; s < 4; s++) read_burst(8 + s, 4);
        read_burst(21, 6);
        // R5: linear order from each start offset, wrapping
        tag = "R5"; order_sel = 0;
        for (int s = 0; s < 4; s++) read_burst(32 + s, 4);
        read_burst(47, 6);

        // R9: output enable toggling within a burst
        tag = "R9"; order_sel = 1;
        load_c(12); tick();
        quiet(); oe_n = 1; adv_n = 0; tick();
        oe_n = 0; tick();
        oe_n = 1; tick(); oe_n = 0; tick();

        // R7: byte-lane writes, then all strobes inactive is a read
        tag = "R7";
        load_c(16); gw_n = 1; bwe_n = 0; bw_n = 4'b1010; din = '1; tick();
        quiet(); adv_n = 0; bwe_n = 0; bw_n = 4'b0111; din = {DW{1'b0}}; tick();
        quiet(); adv_n = 0; bwe_n = 0; bw_n = 4'b1111; din = '1; tick();
        quiet(); tick();
        read_burst(16, 4);

        // R8: byte enable high blocks lane strobes
        tag = "R8";
        load_c(20); bwe_n = 1; bw_n = 4'b0000; din = '1; tick();
        quiet(); adv_n = 0; bw_n = 4'b0000; din = '1; tick();
        read_burst(20, 4);

        // R2: processor strobe qualified by master enable
        tag = "R2";
        quiet(); strobe_p_n = 0; addr = 6'd40; tick();
        quiet(); adv_n = 0; tick();
        quiet(); ce_main_n = 1; strobe_p_n = 0; addr = 6'd3; tick();
        quiet(); tick();
        quiet(); strobe_p_n = 0; ce_hi = 0; addr = 6'd5; tick();
        quiet(); tick();
        quiet(); strobe_p_n = 0; ce_lo_n = 1; ce_main_n = 1; strobe_c_n = 1; addr = 6'd7; tick();
        quiet(); adv_n = 0; tick();

        // R3: controller strobe needs all three enables
        tag = "R3";
        load_c(50); tick();
        load_c(51); ce_main_n = 1; tick();
        quiet(); adv_n = 0; tick();
        load_c(52); ce_hi = 0; tick();
        load_c(53); tick();
        load_c(54); ce_lo_n = 1; tick();
        quiet(); tick();

        // R10: snooze ignores writes and loads, hides output
        tag = "R10";
        load_c(60); tick();
        snooze = 1; quiet(); tick();
        load_c(60); gw_n = 0; din = '1; tick();
        quiet(); adv_n = 0; gw_n = 0; din = '1; tick();

        // R11: writes refused inside recovery window, accepted after
        tag = "R11"; snooze = 0;
        load_c(24); gw_n = 0; din = pat(1000); tick();
        quiet(); adv_n = 0; gw_n = 0; din = pat(1001); tick();
        quiet(); adv_n = 0; gw_n = 0; din = pat(1002); tick();
        quiet(); tick();
        read_burst(24, 4);
        read_burst(60, 4);
        // read accepted in window
        snooze = 1; quiet(); tick(); tick();
        snooze = 0; read_burst(28, 4);
        tick();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule